// File: doc/BRIEF.md
# USB Full-Speed Transmit Serializer

This block turns a packet offered one byte at a time into the serial line signalling of a full-speed USB transmitter. The first byte of each packet is the packet identifier; a two-bit kind input, sampled with that byte, tells the block whether to follow the payload with a 5-bit token checksum, a 16-bit data checksum, or nothing. The block places the synchronisation pattern in front, shifts every byte out least significant bit first, adds the checksum, inserts a zero after each run of six ones, NRZI-encodes the result and closes with the end-of-packet signalling. A driver enable output frames the transmission.

One clock cycle is one bit time, so the block runs on the 12 MHz bit clock. The source sees a valid/ready handshake. Ready is high while the block is idle, which accepts the identifier. After that, ready is asserted only during the bit time that sends the last bit of the current byte, which pulls in the next byte. The source either marks its final byte with the last flag or simply stops offering bytes.

Top module: `usb_tx_serializer`

## Requirements
- R1: After reset, and whenever no packet is being sent, oe is 0, the line rests at J (dp=1, dm=0) and tx_ready is 1.
- R2: A packet accepted on a clock edge with tx_valid and tx_ready high starts with oe rising two sampling points later. The first eight bit times carry seven zero bits and then a one bit, which appear on the line as K J K J K J K K.
- R3: Every byte, including the identifier, is sent least significant bit first. A zero bit toggles the line between J and K and a one bit keeps it. The reference level before the first bit is J.
- R4: After six consecutive one bits, counted across the sync pattern, the payload and the checksum, a zero bit is inserted. The inserted zero toggles the line like any zero and restarts the count. No more than seven consecutive bit times at the same J or K level ever appear.
- R5: With tx_kind = 2'b01 (token), the block takes exactly two bytes after the identifier. It sends all 8 bits of the first, then the 3 low bits of the second, and drops the other 5 bits and the last flag. These 11 bits are followed by the complement of a CRC with polynomial x^5+x^2+1, preset to all ones, sent highest bit first. For identifier 0x2D with bytes 0x00,0x00, the five checksum bits sent are 0,1,0,0,0.
- R6: With tx_kind = 2'b10 or 2'b11 (data), every byte after the identifier is followed by the complement of a CRC with polynomial x^16+x^15+x^2+1. The CRC is preset to all ones, covers the bytes after the identifier only, and is sent highest bit first. A data packet that has only its identifier sends sixteen zero bits as its checksum.
- R7: With tx_kind = 2'b00 (handshake), the identifier is the whole packet and no checksum is sent.
- R8: Every packet ends with two bit times of SE0 (dp=0, dm=0), then one bit time of J, and then oe falls.
- R9: While a packet is in progress, tx_ready is high only in the bit time that sends the final bit of a byte when a further byte is wanted. On that edge the offered byte is loaded, with no gap on the line.
- R10: If tx_valid is low when a further byte is wanted, the packet is closed as though the previous byte had carried the last flag, with its checksum and end-of-packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one cycle per bit time |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | A byte is offered on tx_data |
| tx_ready | output | 1 | The offered byte is taken on this edge |
| tx_data | input | 8 | Packet byte; the first of a packet is the identifier |
| tx_last | input | 1 | This byte ends the packet (ignored for tokens) |
| tx_kind | input | 2 | Packet kind, sampled with the identifier: 00 handshake, 01 token, 1x data |
| dp | output | 1 | Positive line of the differential pair |
| dm | output | 1 | Negative line of the differential pair |
| oe | output | 1 | Line driver enable |

## Verification
A handshake identifier shows framing and NRZI alone, with no checksum. Two tokens follow: one all-zero token with a known checksum, and one whose second byte has junk in its upper bits, which shows that only 11 bits enter the 5-bit checksum. Several data packets (empty, ordinary, long runs of 0xFF that force stuffed bits, and the alternate kind code) separate the 16-bit checksum path, its preset, and stuffing across byte boundaries. A packet whose source stops without a last flag, and a reset in the middle of a packet, show the two ways a packet ends early.

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer #(
  parameter logic [4:0]  TOKEN_POLY = 5'h05,
  parameter logic [15:0] DATA_POLY  = 16'h8005
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  input  logic       tx_last,
  input  logic [1:0] tx_kind,
  output logic       dp,
  output logic       dm,
  output logic       oe
);

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_BYTE, S_CRC, S_EOP} state_t;

  state_t      st;
  logic [3:0]  cnt;
  logic [7:0]  sh;
  logic        last_r;
  logic [1:0]  kind_r;
  logic [1:0]  idx;
  logic [15:0] crc;
  logic [2:0]  ones;
  logic        line, se0, oe_r;

  logic is_tok, has_crc, stuff, byte_end, want_more, emit, bit_src, ebit, crc_msb;
  logic [3:0]  crc_top;
  logic [4:0]  crc5_n;
  logic [15:0] crc16_n, crc_next;

  assign is_tok    = (kind_r == 2'b01);
  assign has_crc   = (kind_r != 2'b00);
  assign stuff     = (ones == 3'd6);
  assign crc_top   = is_tok ? 4'd4 : 4'd15;
  assign crc_msb   = is_tok ? crc[4] : crc[15];
  assign byte_end  = (is_tok && idx == 2'd2) ? (cnt == 4'd2) : (cnt == 4'd7);
  assign want_more = is_tok ? (idx != 2'd2) : !last_r;
  assign tx_ready  = (st == S_IDLE) || (st == S_BYTE && byte_end && !stuff && want_more);

  assign crc5_n   = {crc[3:0], 1'b0} ^ ((sh[0] ^ crc[4]) ? TOKEN_POLY : 5'd0);
  assign crc16_n  = {crc[14:0], 1'b0} ^ ((sh[0] ^ crc[15]) ? DATA_POLY : 16'd0);
  assign crc_next = is_tok ? {11'd0, crc5_n} : crc16_n;

  always_comb begin
    case (st)
      S_SYNC:  bit_src = (cnt == 4'd7);
      S_BYTE:  bit_src = sh[0];
      S_CRC:   bit_src = ~crc_msb;
      default: bit_src = 1'b1;
    endcase
  end

  assign emit = (st == S_SYNC) || (st == S_BYTE) || (st == S_CRC) || (st == S_EOP && stuff);
  assign ebit = stuff ? 1'b0 : bit_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      last_r <= 1'b0;
      kind_r <= 2'b00;
      idx    <= '0;
      crc    <= '1;
      ones   <= '0;
      line   <= 1'b1;
      se0    <= 1'b0;
      oe_r   <= 1'b0;
    end else begin
      if (emit) begin
        line <= ebit ? line : ~line;
        ones <= ebit ? ones + 3'd1 : 3'd0;
        oe_r <= 1'b1;
      end
      case (st)
        S_IDLE: if (tx_valid) begin
          sh     <= tx_data;
          last_r <= tx_last;
          kind_r <= tx_kind;
          idx    <= '0;
          crc    <= '1;
          cnt    <= '0;
          ones   <= '0;
          st     <= S_SYNC;
        end
        S_SYNC: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            cnt <= '0;
            st  <= S_BYTE;
          end
        end
        S_BYTE: if (!stuff) begin
          if (has_crc && idx != 2'd0) crc <= crc_next;
          sh  <= sh >> 1;
          cnt <= cnt + 4'd1;
          if (byte_end) begin
            cnt <= '0;
            if (want_more && tx_valid) begin
              sh     <= tx_data;
              last_r <= tx_last;
              if (idx != 2'd2) idx <= idx + 2'd1;
            end else begin
              st <= has_crc ? S_CRC : S_EOP;
            end
          end
        end
        S_CRC: if (!stuff) begin
          crc <= crc << 1;
          cnt <= cnt + 4'd1;
          if (cnt == crc_top) begin
            cnt <= '0;
            st  <= S_EOP;
          end
        end
        S_EOP: if (!stuff) begin
          cnt  <= cnt + 4'd1;
          ones <= '0;
          case (cnt)
            4'd0, 4'd1: se0 <= 1'b1;
            4'd2: begin
              se0  <= 1'b0;
              line <= 1'b1;
            end
            default: begin
              oe_r <= 1'b0;
              cnt  <= '0;
              st   <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dp = se0 ? 1'b0 : line;
  assign dm = se0 ? 1'b0 : ~line;
  assign oe = oe_r;

endmodule

module usb_tx_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic dp,
  input logic dm,
  input logic oe
);
  logic       se0_l, prev_dp;
  logic [3:0] run;

  assign se0_l = !dp && !dm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= '0;
      prev_dp <= 1'b1;
    end else begin
      prev_dp <= dp;
      if (!oe || se0_l)                run <= '0;
      else if (run != 0 && dp == prev_dp) run <= (run == 4'hF) ? run : run + 4'd1;
      else                              run <= 4'd1;
    end
  end

  a_r1_idle_is_j: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (dp && !dm));

  a_r2_first_bit_k: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> (!dp && dm));

  a_r4_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 4'd7);

  a_r8_se0_min_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(se0_l) |=> se0_l);

  a_r8_se0_max_two: assert property (@(posedge clk) disable iff (!rst_n)
    (se0_l && $past(se0_l)) |=> !se0_l);

  a_r8_j_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> ($past(dp) && !$past(dm)));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !oe) |=> !tx_ready);

endmodule

bind usb_tx_serializer usb_tx_serializer_chk u_chk (.*);

// File: tb/sim_usb_tx_serializer.sv
module sim_usb_tx_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_valid = 1'b0, tx_last = 1'b0;
  logic [7:0] tx_data = '0;
  logic [1:0] tx_kind = '0;
  logic tx_ready, dp, dm, oe;

  int checks = 0, failures = 0;

  usb_tx_serializer u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_kind(tx_kind),
    .dp(dp), .dm(dm), .oe(oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {kind, count, use_last, b0..b4}
  localparam logic [45:0] VEC [NVEC] = '{
    {2'b00, 3'd1, 1'b1, 8'hD2, 32'h0},
    {2'b01, 3'd3, 1'b1, 8'h2D, 8'h00, 8'h00, 16'h0},
    {2'b01, 3'd3, 1'b0, 8'hE1, 8'hBA, 8'hFA, 16'h0},
    {2'b10, 3'd1, 1'b1, 8'hC3, 32'h0},
    {2'b10, 3'd4, 1'b1, 8'h4B, 8'h01, 8'h02, 8'h03, 8'h00},
    {2'b10, 3'd5, 1'b1, 8'hC3, 8'hFF, 8'hFF, 8'h7F, 8'hFF},
    {2'b11, 3'd2, 1'b1, 8'h4B, 8'hA5, 24'h0},
    {2'b10, 3'd3, 1'b0, 8'hC3, 8'h12, 8'h34, 16'h0}
  };
  localparam string TAG [NVEC] = '{"R7", "R5", "R5", "R6", "R3", "R4", "R6", "R10"};

  logic [7:0] pkt [5];
  bit raw [160];
  int rn;
  bit pay [64];
  int pn;
  int exp_sym [200];
  int en;
  int got [200];
  int gn;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int sym();
    if (dp && !dm) return 1;
    if (!dp && dm) return 0;
    if (!dp && !dm) return 2;
    return 3;
  endfunction

  task automatic push_raw(input bit b);
    raw[rn] = b;
    rn = rn + 1;
  endtask

  task automatic build_exp(input logic [1:0] k, input int n);
    logic [4:0]  c5;
    logic [15:0] c16;
    int lvl, run1;
    rn = 0; pn = 0; en = 0;
    for (int i = 0; i < 7; i++) push_raw(1'b0);
    push_raw(1'b1);
    for (int i = 0; i < 8; i++) push_raw(pkt[0][i]);
    if (k == 2'b01) begin
      for (int i = 0; i < 8; i++) begin pay[pn] = pkt[1][i]; pn = pn + 1; end
      for (int i = 0; i < 3; i++) begin pay[pn] = pkt[2][i]; pn = pn + 1; end
    end else if (k != 2'b00) begin
      for (int j = 1; j < n; j++)
        for (int i = 0; i < 8; i++) begin pay[pn] = pkt[j][i]; pn = pn + 1; end
    end
    for (int i = 0; i < pn; i++) push_raw(pay[i]);
    if (k == 2'b01) begin
      c5 = 5'h1F;
      for (int i = 0; i < pn; i++)
        c5 = (c5[0] ^ pay[i]) ? ((c5 >> 1) ^ 5'h14) : (c5 >> 1);
      for (int i = 0; i < 5; i++) push_raw(~c5[i]);
    end else if (k != 2'b00) begin
      c16 = 16'hFFFF;
      for (int i = 0; i < pn; i++)
        c16 = (c16[0] ^ pay[i]) ? ((c16 >> 1) ^ 16'hA001) : (c16 >> 1);
      for (int i = 0; i < 16; i++) push_raw(~c16[i]);
    end
    lvl = 1; run1 = 0;
    for (int i = 0; i < rn; i++) begin
      if (!raw[i]) begin lvl = 1 - lvl; run1 = 0; end
      else run1 = run1 + 1;
      exp_sym[en] = lvl; en = en + 1;
      if (run1 == 6) begin
        lvl = 1 - lvl; run1 = 0;
        exp_sym[en] = lvl; en = en + 1;
      end
    end
    exp_sym[en] = 2; exp_sym[en+1] = 2; exp_sym[en+2] = 1;
    en = en + 3;
  endtask

  task automatic run_pkt(input logic [1:0] k, input int n, input bit use_last, input string tag);
    int bi = 0, tacc = -1, tfirst = -1, bad = -1;
    bit seen = 0;
    gn = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (oe) begin
        if (!seen) tfirst = c;
        seen = 1;
        if (gn < 200) got[gn] = sym();
        gn = gn + 1;
      end else if (seen) begin
        break;
      end
      if (tx_ready && bi < n) begin
        tx_valid = 1'b1;
        tx_data  = pkt[bi];
        tx_last  = use_last && (bi == n - 1);
        tx_kind  = k;
        if (bi == 0) tacc = c;
        bi = bi + 1;
      end else begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
      end
    end
    tx_valid = 1'b0;
    check(gn == en, tag, "bit-time count", gn, en);
    for (int i = 0; i < en && i < gn; i++)
      if (bad < 0 && got[i] != exp_sym[i]) bad = i;
    check(bad < 0, tag, "line symbol mismatch index", bad, -1);
    check(gn >= 3 && got[gn-3] == 2 && got[gn-2] == 2 && got[gn-1] == 1,
          "R8", "end-of-packet tail", (gn >= 1) ? got[gn-1] : -1, 1);
    check(tfirst - tacc == 2, "R2", "accept to first bit", tfirst - tacc, 2);
    check(tx_ready && dp && !dm && !oe, "R9", "ready and J after packet",
          {tx_ready, dp, dm, oe}, 4'b1100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [45:0] e;
    repeat (3) @(negedge clk);
    check(!oe && dp && !dm && tx_ready, "R1", "reset state", {oe, dp, dm, tx_ready}, 4'b0101);
    rst_n = 1'b1;
    @(negedge clk);
    check(!oe && dp && !dm && tx_ready, "R1", "idle after reset", {oe, dp, dm, tx_ready}, 4'b0101);

    for (int v = 0; v < NVEC; v++) begin
      e = VEC[v];
      pkt[0] = e[39:32]; pkt[1] = e[31:24]; pkt[2] = e[23:16];
      pkt[3] = e[15:8];  pkt[4] = e[7:0];
      build_exp(e[45:44], int'(e[43:41]));
      run_pkt(e[45:44], int'(e[43:41]), e[40], TAG[v]);
    end

    // reset in the middle of a packet returns to idle at once (R1)
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 8'hC3; tx_kind = 2'b10; tx_last = 1'b0;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (12) @(negedge clk);
    check(oe == 1'b1, "R2", "packet in progress before reset", oe, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!oe && dp && !dm && tx_ready, "R1", "reset mid-packet", {oe, dp, dm, tx_ready}, 4'b0101);
    rst_n = 1'b1;
    @(negedge clk);
    pkt[0] = 8'h5A;
    build_exp(2'b00, 1);
    run_pkt(2'b00, 1, 1'b1, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule